// File: doc/BRIEF.md
# Memory-Reference Effective Address Generator

This block turns the addressing part of a 32-bit load or store instruction into a 64-bit effective address. Each cycle it can accept one request made of the instruction word, the address of that instruction, a load/store flag and an operand-size code. It decodes the addressing fields and drives two register-file read addresses: one for the base register and one for the index register. The register file answers in the same cycle. The block then adds base, displacement and index. One cycle after the request it presents the address, a flag that says whether an index register took part, an illegal-encoding flag and a register writeback request.

Five address forms are supported:
- a long-base form using registers 25..31;
- a global-area form based on register 16;
- a short-base form using registers 17..23;
- a program-relative form with a signed displacement;
- register indirect, either plain or with scaled auto-increment or auto-decrement.

For the auto-update forms, the step equals the operand size. A load uses the register's old value as its address. A store uses the updated value. In both cases the updated value is sent out as a writeback for the pipeline to commit.

Instruction layout: bits 31:27 carry the destination register and are not used here. Bits 26:24 hold the index field. Bits 23:0 hold the addressing part.

Top module: `mem_ea_gen`

## Requirements
- R1: Index field instr[26:24] equal to 0 means no index: idx_used_o is 0 and nothing is added. A value of 1..7 reads that general register on raddr_b_o, adds its value to the address and sets idx_used_o.
- R2: Long-base form (instr[23:22]=11). Base field instr[21:19] = 1..7 selects register 25..31. The address is that register plus instr[18:0] zero-extended. A base field of 0 is illegal.
- R3: Global form (instr[23:22]=10). The address is register 16 plus instr[14:0] zero-extended. Bits 21:15 are ignored.
- R4: Short-base form (instr[23]=0, short field instr[22:20]=1..7) selects register 17..23. The address is that register plus instr[11:0] zero-extended.
- R5: Program-relative form (instr[23]=0, instr[22:20]=0, instr[19:18]=00). The address is pc_i+4 plus instr[9:0] sign-extended, giving -512..511 bytes.
- R6: Register-indirect form (instr[23]=0, instr[22:20]=0, instr[19:18]=01). instr[4:0] names any of 32 registers. Submode instr[17:15]=000 gives that register's value as the address, with no writeback.
- R7: Size code size_i sets the auto-update step: 000→1, 001→2, 010→4, 011→6, 100→8 bytes.
- R8: Submode 010 adds the step and submode 011 subtracts it, modulo 2^64. The result is requested on wb_en_o/wb_reg_o/wb_data_o. For a load (is_store_i=0), the address uses the register's old value.
- R9: For a store (is_store_i=1) with submode 010 or 011, the address uses the updated register value, plus any index.
- R10: The following encodings are illegal:
  - instr[19:18] of 10 or 11 in the zero-short-field space;
  - a register-indirect submode other than 000, 010 or 011;
  - a long-base field of 0;
  - a size code of 101..111.

  An illegal request raises illegal_o with ea_o, idx_used_o, wb_en_o, wb_reg_o and wb_data_o all 0.
- R11: Results appear exactly one cycle after valid_i. valid_o is 0 in cycles with no request. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| is_store_i | input | 1 | 1 for a store, 0 for a load |
| size_i | input | 3 | Operand-size code |
| raddr_a_o | output | 5 | Base register read address |
| rdata_a_i | input | XLEN | Base register read data (same cycle) |
| raddr_b_o | output | 5 | Index register read address |
| rdata_b_i | input | XLEN | Index register read data (same cycle) |
| valid_o | output | 1 | Result valid |
| ea_o | output | XLEN | Effective address |
| idx_used_o | output | 1 | An index register was added |
| illegal_o | output | 1 | Undefined encoding |
| wb_en_o | output | 1 | Auto-update writeback request |
| wb_reg_o | output | 5 | Writeback register number |
| wb_data_o | output | XLEN | Updated register value |

## Verification
The bench instantiates the block with its default XLEN of 64. It models a 32-entry register file holding extreme values: zero, all ones, and large patterns. With 64-bit arithmetic and those values, several wrap cases become reachable:
- auto-decrement past zero;
- auto-increment past the top of the address space;
- program-relative offsets that carry below address zero.

Every size code and every register-mapping endpoint (25, 31, 17, 23, 16) is driven. Requests are issued both back to back and with idle gaps between them.

// File: rtl/mem_ea_gen_pkg.sv
package mem_ea_gen_pkg;

    localparam int unsigned DISP_W   = 19;
    localparam int unsigned PCREL_W  = 10;
    localparam int unsigned REG_W    = 5;
    localparam int unsigned INSTR_B  = 4;

    typedef enum logic [2:0] {
        AM_LONG   = 3'd0,
        AM_GLOBAL = 3'd1,
        AM_SHORT  = 3'd2,
        AM_PCREL  = 3'd3,
        AM_RIND   = 3'd4,
        AM_BAD    = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_INC  = 2'd1,
        UPD_DEC  = 2'd2
    } upd_e;

    typedef struct packed {
        amode_e             mode;
        logic [REG_W-1:0]   base_reg;
        logic [REG_W-1:0]   idx_reg;
        logic               idx_en;
        upd_e               upd;
        logic [DISP_W-1:0]  disp;
        logic               disp_signed;
        logic               use_pc;
        logic               bad;
    } dec_t;

endpackage

// File: rtl/mem_ea_gen_decode.sv
module mem_ea_gen_decode
    import mem_ea_gen_pkg::*;
(
    input  logic [31:0] instr_i,
    output dec_t        dec_o
);

    logic [2:0] idx_f;
    logic [2:0] long_b;
    logic [2:0] short_b;
    logic [1:0] sub_sel;
    logic [2:0] rind_m;
    logic [4:0] unused_dst;

    assign idx_f      = instr_i[26:24];
    assign long_b     = instr_i[21:19];
    assign short_b    = instr_i[22:20];
    assign sub_sel    = instr_i[19:18];
    assign rind_m     = instr_i[17:15];
    assign unused_dst = instr_i[31:27];

    always_comb begin
        dec_o             = '0;
        dec_o.mode        = AM_BAD;
        dec_o.idx_en      = (idx_f != 3'd0);
        dec_o.idx_reg     = {2'b00, idx_f};
        dec_o.upd         = UPD_NONE;
        if (instr_i[23]) begin
            if (instr_i[22]) begin
                dec_o.mode     = AM_LONG;
                dec_o.base_reg = 5'd24 + {2'b00, long_b};
                dec_o.disp     = instr_i[DISP_W-1:0];
                dec_o.bad      = (long_b == 3'd0);
            end else begin
                dec_o.mode     = AM_GLOBAL;
                dec_o.base_reg = 5'd16;
                dec_o.disp     = {4'b0000, instr_i[14:0]};
            end
        end else if (short_b != 3'd0) begin
            dec_o.mode     = AM_SHORT;
            dec_o.base_reg = 5'd16 + {2'b00, short_b};
            dec_o.disp     = {7'b0, instr_i[11:0]};
        end else begin
            unique case (sub_sel)
                2'b00: begin
                    dec_o.mode        = AM_PCREL;
                    dec_o.use_pc      = 1'b1;
                    dec_o.disp_signed = 1'b1;
                    dec_o.disp        = {9'b0, instr_i[PCREL_W-1:0]};
                end
                2'b01: begin
                    dec_o.mode     = AM_RIND;
                    dec_o.base_reg = instr_i[4:0];
                    unique case (rind_m)
                        3'b000:  dec_o.upd = UPD_NONE;
                        3'b010:  dec_o.upd = UPD_INC;
                        3'b011:  dec_o.upd = UPD_DEC;
                        default: dec_o.bad = 1'b1;
                    endcase
                end
                default: begin
                    dec_o.mode = AM_BAD;
                    dec_o.bad  = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/mem_ea_gen_step.sv
module mem_ea_gen_step #(
    parameter int unsigned XLEN = 64
) (
    input  logic [2:0]      size_i,
    output logic [XLEN-1:0] step_o,
    output logic            bad_o
);

    localparam int unsigned SW = 4;

    logic [SW-1:0] bytes;

    always_comb begin
        bad_o = 1'b0;
        unique case (size_i)
            3'b000:  bytes = 4'd1;
            3'b001:  bytes = 4'd2;
            3'b010:  bytes = 4'd4;
            3'b011:  bytes = 4'd6;
            3'b100:  bytes = 4'd8;
            default: begin
                bytes = 4'd0;
                bad_o = 1'b1;
            end
        endcase
        step_o = {{(XLEN-SW){1'b0}}, bytes};
    end

endmodule

// File: rtl/mem_ea_gen_sum.sv
module mem_ea_gen_sum
    import mem_ea_gen_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  dec_t            dec_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] base_val_i,
    input  logic [XLEN-1:0] idx_val_i,
    input  logic [XLEN-1:0] step_i,
    input  logic            is_store_i,
    output logic [XLEN-1:0] ea_o,
    output logic [XLEN-1:0] upd_val_o
);

    localparam int unsigned ZPAD = XLEN - DISP_W;
    localparam int unsigned SPAD = XLEN - PCREL_W;
    localparam logic [XLEN-1:0] NEXT_OFS = XLEN'(INSTR_B);

    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] base_sel;
    logic [XLEN-1:0] addr_base;
    logic [XLEN-1:0] idx_add;

    always_comb begin
        if (dec_i.disp_signed) begin
            disp_ext = {{SPAD{dec_i.disp[PCREL_W-1]}}, dec_i.disp[PCREL_W-1:0]};
        end else begin
            disp_ext = {{ZPAD{1'b0}}, dec_i.disp};
        end

        base_sel = dec_i.use_pc ? (pc_i + NEXT_OFS) : base_val_i;

        unique case (dec_i.upd)
            UPD_INC: upd_val_o = base_sel + step_i;
            UPD_DEC: upd_val_o = base_sel - step_i;
            default: upd_val_o = base_sel;
        endcase

        addr_base = (is_store_i && (dec_i.upd != UPD_NONE)) ? upd_val_o : base_sel;
        idx_add   = dec_i.idx_en ? idx_val_i : '0;
        ea_o      = addr_base + disp_ext + idx_add;
    end

endmodule

// File: rtl/mem_ea_gen.sv
module mem_ea_gen
    import mem_ea_gen_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic [31:0]      instr_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic             is_store_i,
    input  logic [2:0]       size_i,
    output logic [REG_W-1:0] raddr_a_o,
    input  logic [XLEN-1:0]  rdata_a_i,
    output logic [REG_W-1:0] raddr_b_o,
    input  logic [XLEN-1:0]  rdata_b_i,
    output logic             valid_o,
    output logic [XLEN-1:0]  ea_o,
    output logic             idx_used_o,
    output logic             illegal_o,
    output logic             wb_en_o,
    output logic [REG_W-1:0] wb_reg_o,
    output logic [XLEN-1:0]  wb_data_o
);

    typedef struct packed {
        logic             valid;
        logic [XLEN-1:0]  ea;
        logic             idx_used;
        logic             illegal;
        logic             wb_en;
        logic [REG_W-1:0] wb_reg;
        logic [XLEN-1:0]  wb_data;
    } res_t;

    dec_t            dec;
    logic [XLEN-1:0] step;
    logic            size_bad;
    logic [XLEN-1:0] ea_raw;
    logic [XLEN-1:0] upd_raw;
    res_t            res_d;
    res_t            res_q;

    mem_ea_gen_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    mem_ea_gen_step #(.XLEN(XLEN)) u_step (
        .size_i (size_i),
        .step_o (step),
        .bad_o  (size_bad)
    );

    mem_ea_gen_sum #(.XLEN(XLEN)) u_sum (
        .dec_i      (dec),
        .pc_i       (pc_i),
        .base_val_i (rdata_a_i),
        .idx_val_i  (rdata_b_i),
        .step_i     (step),
        .is_store_i (is_store_i),
        .ea_o       (ea_raw),
        .upd_val_o  (upd_raw)
    );

    assign raddr_a_o = dec.base_reg;
    assign raddr_b_o = dec.idx_reg;

    always_comb begin
        logic ok;
        ok             = valid_i && !dec.bad && !size_bad;
        res_d          = '0;
        res_d.valid    = valid_i;
        res_d.illegal  = valid_i && !ok;
        if (ok) begin
            res_d.ea       = ea_raw;
            res_d.idx_used = dec.idx_en;
            if (dec.upd != UPD_NONE) begin
                res_d.wb_en   = 1'b1;
                res_d.wb_reg  = dec.base_reg;
                res_d.wb_data = upd_raw;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign valid_o    = res_q.valid;
    assign ea_o       = res_q.ea;
    assign idx_used_o = res_q.idx_used;
    assign illegal_o  = res_q.illegal;
    assign wb_en_o    = res_q.wb_en;
    assign wb_reg_o   = res_q.wb_reg;
    assign wb_data_o  = res_q.wb_data;

endmodule

// File: rtl/mem_ea_gen_chk.sv
module mem_ea_gen_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            valid_i,
    input logic [31:0]     instr_i,
    input logic            is_store_i,
    input logic [4:0]      raddr_a_o,
    input logic [XLEN-1:0] rdata_a_i,
    input logic            valid_o,
    input logic [XLEN-1:0] ea_o,
    input logic            idx_used_o,
    input logic            illegal_o,
    input logic            wb_en_o,
    input logic [4:0]      wb_reg_o,
    input logic [XLEN-1:0] wb_data_o
);

    assert_result_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);

    assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o);

    assert_illegal_blocks_wb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (!wb_en_o && ea_o == '0 && !idx_used_o));

    assert_no_index_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && instr_i[26:24] == 3'd0) |=> !idx_used_o);

    assert_wb_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_en_o |-> (wb_reg_o == $past(raddr_a_o)));

    assert_load_old_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !is_store_i && instr_i[26:24] == 3'd0) |=>
            (!wb_en_o || ea_o == $past(rdata_a_i)));

    assert_store_new_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && is_store_i && instr_i[26:24] == 3'd0) |=>
            (!wb_en_o || ea_o == wb_data_o));

endmodule

bind mem_ea_gen mem_ea_gen_chk #(.XLEN(XLEN)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .instr_i    (instr_i),
    .is_store_i (is_store_i),
    .raddr_a_o  (raddr_a_o),
    .rdata_a_i  (rdata_a_i),
    .valid_o    (valid_o),
    .ea_o       (ea_o),
    .idx_used_o (idx_used_o),
    .illegal_o  (illegal_o),
    .wb_en_o    (wb_en_o),
    .wb_reg_o   (wb_reg_o),
    .wb_data_o  (wb_data_o)
);

// File: tb/mem_ea_gen_tb.sv
module mem_ea_gen_tb;

    localparam int unsigned XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] pc = '0;
    logic            st = 1'b0;
    logic [2:0]      sz = 3'd0;
    logic [4:0]      raddr_a, raddr_b;
    logic [XLEN-1:0] rdata_a, rdata_b;
    logic            valid_o, idx_used_o, illegal_o, wb_en_o;
    logic [XLEN-1:0] ea_o, wb_data_o;
    logic [4:0]      wb_reg_o;

    logic [XLEN-1:0] regs [32];

    always #2 clk = ~clk;

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    mem_ea_gen #(.XLEN(XLEN)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
        .pc_i(pc), .is_store_i(st), .size_i(sz),
        .raddr_a_o(raddr_a), .rdata_a_i(rdata_a),
        .raddr_b_o(raddr_b), .rdata_b_i(rdata_b),
        .valid_o(valid_o), .ea_o(ea_o), .idx_used_o(idx_used_o),
        .illegal_o(illegal_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
        .wb_data_o(wb_data_o)
    );

    typedef struct {
        logic [63:0] ea;
        logic        idx;
        logic        ill;
        logic        wb;
        logic [4:0]  wr;
        logic [63:0] wd;
        string       tag;
    } exp_t;

    exp_t exq [$];
    int   n_chk = 0;
    int   n_bad = 0;

    function automatic logic [63:0] idxv(input logic [2:0] i);
        return (i == 3'd0) ? 64'd0 : regs[i];
    endfunction

    function automatic logic [63:0] stp(input logic [2:0] s);
        case (s)
            3'd0: return 64'd1;
            3'd1: return 64'd2;
            3'd2: return 64'd4;
            3'd3: return 64'd6;
            3'd4: return 64'd8;
            default: return 64'd0;
        endcase
    endfunction

    function automatic exp_t mk(input logic [63:0] ea, input logic [2:0] i,
                                input logic ill, input string tag);
        exp_t e;
        e.ea = ill ? 64'd0 : ea;
        e.idx = !ill && (i != 3'd0);
        e.ill = ill; e.wb = 1'b0; e.wr = '0; e.wd = '0; e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [31:0] ins, input logic [63:0] p,
                         input logic s, input logic [2:0] z, input exp_t e);
        instr = ins; pc = p; st = s; sz = z; valid = 1'b1;
        exq.push_back(e);
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_long(input logic [2:0] i, input logic [2:0] b,
                          input logic [18:0] d, input logic [2:0] z, input string tag);
        logic ill;
        ill = (b == 3'd0) || (z > 3'd4);
        drive({5'd3, i, 2'b11, b, d}, 64'd0, 1'b0, z,
              mk(regs[24 + b] + {45'd0, d} + idxv(i), i, ill, tag));
    endtask

    task automatic t_glob(input logic [2:0] i, input logic [6:0] junk,
                          input logic [14:0] d, input string tag);
        drive({5'd1, i, 2'b10, junk, d}, 64'd0, 1'b1, 3'd2,
              mk(regs[16] + {49'd0, d} + idxv(i), i, 1'b0, tag));
    endtask

    task automatic t_short(input logic [2:0] i, input logic [2:0] b,
                           input logic [11:0] d, input string tag);
        drive({5'd0, i, 1'b0, b, 8'd0, d}, 64'd0, 1'b0, 3'd3,
              mk(regs[16 + b] + {52'd0, d} + idxv(i), i, 1'b0, tag));
    endtask

    task automatic t_pcrel(input logic [2:0] i, input logic [9:0] d,
                           input logic [63:0] p, input string tag);
        drive({5'd0, i, 1'b0, 3'd0, 2'b00, 8'd0, d}, p, 1'b0, 3'd0,
              mk(p + 64'd4 + {{54{d[9]}}, d} + idxv(i), i, 1'b0, tag));
    endtask

    task automatic t_rind(input logic [2:0] i, input logic [2:0] m, input logic [4:0] r,
                          input logic s, input logic [2:0] z, input string tag);
        exp_t e;
        logic ill, upd;
        logic [63:0] nv, ab;
        ill = !(m == 3'b000 || m == 3'b010 || m == 3'b011) || (z > 3'd4);
        upd = (m == 3'b010) || (m == 3'b011);
        nv = (m == 3'b010) ? regs[r] + stp(z) :
             (m == 3'b011) ? regs[r] - stp(z) : regs[r];
        ab = (upd && s) ? nv : regs[r];
        e = mk(ab + idxv(i), i, ill, tag);
        if (upd && !ill) begin
            e.wb = 1'b1; e.wr = r; e.wd = nv;
        end
        drive({5'd0, i, 1'b0, 3'd0, 2'b01, m, 10'd0, r}, 64'd0, s, z, e);
    endtask

    task automatic t_raw_ill(input logic [31:0] ins, input string tag);
        drive(ins, 64'd0, 1'b0, 3'd0, mk(64'd0, 3'd0, 1'b1, tag));
    endtask

    function automatic void chk(input logic ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exq.size() == 0) begin
                chk(1'b0, $sformatf("R11 unexpected result ea=%h", ea_o));
            end else begin
                exp_t e;
                e = exq.pop_front();
                chk(ea_o == e.ea && idx_used_o == e.idx && illegal_o == e.ill &&
                    wb_en_o == e.wb && wb_reg_o == e.wr && wb_data_o == e.wd,
                    $sformatf("%s actual ea=%h idx=%b ill=%b wb=%b r%0d=%h expected ea=%h idx=%b ill=%b wb=%b r%0d=%h",
                              e.tag, ea_o, idx_used_o, illegal_o, wb_en_o, wb_reg_o, wb_data_o,
                              e.ea, e.idx, e.ill, e.wb, e.wr, e.wd));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 32; k++) begin
            regs[k] = 64'h0123_0000_0000_0000 * k + 64'h1000 * k + 64'h10;
        end
        regs[3]  = 64'hFFFF_FFFF_FFFF_FFFC;
        regs[5]  = 64'd0;
        regs[31] = 64'hFFFF_FFFF_FFF0_0000;
        repeat (3) @(negedge clk);
        chk(valid_o == 0 && ea_o == 0 && wb_en_o == 0 && illegal_o == 0 && idx_used_o == 0,
            $sformatf("R11 reset state actual v=%b ea=%h wb=%b expected all 0", valid_o, ea_o, wb_en_o));
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 0, $sformatf("R11 idle after reset actual=%b expected=0", valid_o));

        t_long(3'd0, 3'd1, 19'h7FFFF, 3'd0, "R2 base r25 max disp");
        t_long(3'd3, 3'd7, 19'h00010, 3'd0, "R2 base r31 plus index r3");
        t_long(3'd0, 3'd0, 19'h00001, 3'd0, "R10 long base field zero");
        gap(2);
        t_glob(3'd0, 7'h7F, 15'h7FFF, "R3 global max disp, ignored bits set, R1 no index");
        t_glob(3'd7, 7'h00, 15'h0000, "R3 global with index r7 R1");
        t_short(3'd0, 3'd1, 12'hFFF, "R4 short base r17");
        t_short(3'd2, 3'd7, 12'h001, "R4 short base r23 plus index r2");
        gap(1);
        t_pcrel(3'd0, 10'h200, 64'h100, "R5 pc-relative -512 wraps below zero");
        t_pcrel(3'd0, 10'h1FF, 64'h8000, "R5 pc-relative +511");
        t_pcrel(3'd1, 10'h3FF, 64'h0, "R5 pc-relative -1 with index r1");
        t_rind(3'd0, 3'b000, 5'd9, 1'b0, 3'd4, "R6 plain indirect no writeback");
        t_rind(3'd4, 3'b000, 5'd0, 1'b1, 3'd4, "R6 plain indirect r0 with index r4");
        for (int z = 0; z < 5; z++) begin
            t_rind(3'd0, 3'b010, 5'd20, 1'b0, 3'(z), $sformatf("R7 load inc size code %0d R8", z));
        end
        t_rind(3'd0, 3'b011, 5'd5, 1'b0, 3'd3, "R8 load dec wraps below zero");
        t_rind(3'd0, 3'b010, 5'd3, 1'b0, 3'd4, "R8 load inc wraps at top");
        t_rind(3'd0, 3'b010, 5'd12, 1'b1, 3'd2, "R9 store inc uses updated value");
        t_rind(3'd0, 3'b011, 5'd5, 1'b1, 3'd1, "R9 store dec uses updated value");
        t_rind(3'd6, 3'b011, 5'd8, 1'b1, 3'd4, "R9 store dec plus index r6");
        t_rind(3'd6, 3'b010, 5'd8, 1'b0, 3'd0, "R8 load inc plus index r6");
        gap(3);
        t_rind(3'd0, 3'b001, 5'd8, 1'b0, 3'd0, "R10 indirect submode 001");
        t_rind(3'd2, 3'b111, 5'd8, 1'b1, 3'd0, "R10 indirect submode 111");
        t_rind(3'd0, 3'b010, 5'd8, 1'b0, 3'd5, "R10 size code 101 on auto-update");
        t_long(3'd2, 3'd4, 19'h10, 3'd7, "R10 size code 111 on long base");
        t_raw_ill({5'd0, 3'd0, 1'b0, 3'd0, 2'b10, 18'h3ABCD}, "R10 zero short field sub 10");
        t_raw_ill({5'd0, 3'd5, 1'b0, 3'd0, 2'b11, 18'h00001}, "R10 zero short field sub 11");
        gap(1);
        chk(valid_o == 0, $sformatf("R11 idle gap actual=%b expected=0", valid_o));
        gap(3);
        chk(exq.size() == 0, $sformatf("R11 results outstanding actual=%0d expected=0", exq.size()));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule